// File: doc/BRIEF.md
# Display Backlight PWM Generator

This block produces one pulse-width-modulated output for driving a display backlight. A small register port sets a clock prescaler, a period length and a high-phase length. The output repeats a frame of `(prescaler+1)*(period+1)` input clocks and stays high for the first `high*(prescaler+1)` clocks of each frame. The high-phase field is one bit wider than the period field, so a frame can be fully high as well as fully low.

The timing values written by software land in shadow registers. They reach the counters only after software raises a commit bit, and then only at the end of the frame in progress, so a running frame is never cut short. A direct mode skips the shadow stage, and the counters then follow every write without a commit. A run bit starts and stops the output. Stopping forces the output low and clears the counters, and starting again begins a new frame.

Top module: `backlight_pwm`

## Requirements
- R1: After a synchronous active-low reset, `pwm_o` is low and every register reads back as zero.
- R2: With the output running, one frame lasts `(div+1)*(per+1)` clock cycles, where `div` is the prescaler and `per` is the period field.
- R3: Each frame starts with a high phase of `high*(div+1)` cycles and is low for the rest of the frame. A high field of 0 keeps the output low for the whole frame.
- R4: A high field greater than `per` holds the output high for the entire frame, every frame.
- R5: In buffered mode, writes to the timing registers do not change the output until a commit. A read returns the value last written, not the value in use.
- R6: Only a 0-to-1 change of the commit bit (address 0xC, bit 0) arms a transfer. Writing 1 while the bit is already 1 arms nothing. An armed transfer copies the shadow values into the counters at the end of the current frame, so the current frame completes with the old values. While the output is stopped, the copy happens on the next cycle.
- R7: With the direct bit (address 0x4, bit 0) set to 1, timing writes take effect one cycle after they are written, and no commit is needed.
- R8: Clearing the run bit (address 0x0, bit 0) drives `pwm_o` low from the next cycle and holds it low. Setting the bit starts a new frame that begins with its high phase on the first cycle.
- R9: Register layout. Address 0x0 holds run in bit 0. Address 0x4 holds direct in bit 0 and the prescaler in bits 25:16. Address 0x8 holds the period in bits 11:0 and the high width in bits 28:16. Address 0xC holds commit in bit 0. Unused bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and counters |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe; the write is captured on the rising clock edge |
| reg_addr_i | input | 4 | Register byte address, used for both reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
The bench sweeps the prescaler, period and high-width fields, including a zero high width, a high width exactly one more than the period, a high width far above the period, and the largest field values. A design that compared the high width against a period-sized field, or miscounted the prescaler, would give the wrong number of high cycles or the wrong frame length. It raises a commit in the middle of a frame and checks that the old high phase is still there. A design that loaded the new values at once would cut that frame short. It also writes a 1 over a commit bit that is already 1, and a design that triggered on the bit level instead of its 0-to-1 change would switch settings too early. Further tests check the direct mode, the low output after the run bit is cleared, and the high first cycle after it is set again. A design that failed any of these would show stale settings, a stuck output, or a late first pulse.

// File: rtl/bl_pwm_pkg.sv
// Shared constants and types for the backlight PWM generator.
// Assumes word-aligned byte addresses on a 4-bit register port.
package bl_pwm_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int DIV_W  = 10;
    localparam int PER_W  = 12;
    localparam int HI_W   = PER_W + 1;

    localparam int DIV_LSB    = 16;
    localparam int PER_LSB    = 0;
    localparam int HI_LSB     = 16;
    localparam int RUN_BIT    = 0;
    localparam int DIRECT_BIT = 0;
    localparam int CMT_BIT    = 0;

    localparam logic [ADDR_W-1:0] ADDR_RUN = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_CFG = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_TIM = 4'h8;
    localparam logic [ADDR_W-1:0] ADDR_CMT = 4'hC;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [HI_W-1:0]  high;
    } bl_timing_t;

endpackage

// File: rtl/bl_pwm_regs.sv
// Register file: holds the run, direct and commit bits and the shadow
// timing fields, drives combinational read data, and raises a one-cycle
// arm pulse when the commit bit goes from 0 to 1.
// Assumes a single write strobe sampled on the rising clock edge.
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              run_o,
    output logic              direct_o,
    output bl_timing_t        shadow_o,
    output logic              arm_o
);

    logic             run_q;
    logic             direct_q;
    logic             cmt_q;
    logic [DIV_W-1:0] div_q;
    logic [PER_W-1:0] per_q;
    logic [HI_W-1:0]  hi_q;

    // Capture register writes; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            direct_q <= 1'b0;
            cmt_q    <= 1'b0;
            div_q    <= '0;
            per_q    <= '0;
            hi_q     <= '0;
        end else if (wr_i) begin
            case (addr_i)
                ADDR_RUN: run_q <= wdata_i[RUN_BIT];
                ADDR_CFG: begin
                    direct_q <= wdata_i[DIRECT_BIT];
                    div_q    <= wdata_i[DIV_LSB +: DIV_W];
                end
                ADDR_TIM: begin
                    per_q <= wdata_i[PER_LSB +: PER_W];
                    hi_q  <= wdata_i[HI_LSB +: HI_W];
                end
                ADDR_CMT: cmt_q <= wdata_i[CMT_BIT];
                default: ;
            endcase
        end
    end

    // Read mux returning the stored (shadow) values.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_RUN: rdata_o[RUN_BIT] = run_q;
            ADDR_CFG: begin
                rdata_o[DIRECT_BIT]         = direct_q;
                rdata_o[DIV_LSB +: DIV_W]   = div_q;
            end
            ADDR_TIM: begin
                rdata_o[PER_LSB +: PER_W]   = per_q;
                rdata_o[HI_LSB +: HI_W]     = hi_q;
            end
            ADDR_CMT: rdata_o[CMT_BIT] = cmt_q;
            default: ;
        endcase
    end

    // Arm only on a 0-to-1 change of the commit bit.
    always_comb begin
        arm_o = wr_i && (addr_i == ADDR_CMT) && wdata_i[CMT_BIT] && !cmt_q;
    end

    assign run_o    = run_q;
    assign direct_o = direct_q;
    assign shadow_o = '{div: div_q, per: per_q, high: hi_q};

    AST_ARM_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        arm_o |=> cmt_q); // R6

    AST_BIT_HELD_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_q |-> !arm_o); // R6

endmodule

// File: rtl/bl_pwm_shadow.sv
// Double buffer: moves the shadow timing into the active set. In buffered
// mode an armed transfer waits for a frame boundary; in direct mode the
// active set follows the shadow every cycle.
// Assumes boundary_i is high whenever the counters are stopped.
module bl_pwm_shadow
    import bl_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bl_timing_t shadow_i,
    input  logic       direct_i,
    input  logic       arm_i,
    input  logic       boundary_i,
    output bl_timing_t active_o
);

    bl_timing_t active_q;
    logic       pending_q;

    // Track an armed transfer and load the active set at the right time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= '0;
            pending_q <= 1'b0;
        end else if (direct_i) begin
            active_q  <= shadow_i;
            pending_q <= 1'b0;
        end else if (pending_q && boundary_i) begin
            active_q  <= shadow_i;
            pending_q <= arm_i;
        end else if (arm_i) begin
            pending_q <= 1'b1;
        end
    end

    assign active_o = active_q;

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_i && !pending_q) |=> $stable(active_q)); // R5

endmodule

// File: rtl/bl_pwm_counter.sv
// Frame counters: a prescale counter steps a period counter; the output
// is high while the period count is below the high width. Stopping clears
// both counters. Assumes HI_W is one bit wider than PER_W.
module bl_pwm_counter
    import bl_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  bl_timing_t active_i,
    output logic       boundary_o,
    output logic       pwm_o
);

    logic [DIV_W-1:0] dcnt_q;
    logic [PER_W-1:0] pcnt_q;
    logic             div_end;
    logic             per_end;

    // End-of-step and end-of-frame detection (>= tolerates direct-mode shrink).
    always_comb begin
        div_end    = (dcnt_q >= active_i.div);
        per_end    = (pcnt_q >= active_i.per);
        boundary_o = !run_i || (div_end && per_end);
    end

    // Prescale and period counting; held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            dcnt_q <= '0;
            pcnt_q <= '0;
        end else if (div_end) begin
            dcnt_q <= '0;
            pcnt_q <= per_end ? '0 : pcnt_q + PER_W'(1);
        end else begin
            dcnt_q <= dcnt_q + DIV_W'(1);
        end
    end

    // Output compare against the wider high-width field.
    always_comb begin
        pwm_o = run_i && (HI_W'(pcnt_q) < active_i.high);
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (dcnt_q == '0 && pcnt_q == '0)); // R8

    AST_FRESH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_i) && active_i.high != '0) |-> pwm_o); // R8

endmodule

// File: rtl/backlight_pwm.sv
// Top of the backlight PWM generator: register file, double buffer and
// frame counters. Assumes one clock domain and a synchronous active-low reset.
module backlight_pwm
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              pwm_o
);

    logic       run;
    logic       direct;
    logic       arm;
    logic       boundary;
    bl_timing_t shadow;
    bl_timing_t active;

    bl_pwm_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .run_o    (run),
        .direct_o (direct),
        .shadow_o (shadow),
        .arm_o    (arm)
    );

    bl_pwm_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .shadow_i   (shadow),
        .direct_i   (direct),
        .arm_i      (arm),
        .boundary_i (boundary),
        .active_o   (active)
    );

    bl_pwm_counter u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .active_i   (active),
        .boundary_o (boundary),
        .pwm_o      (pwm_o)
    );

    AST_NO_MIDFRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !boundary && !direct) |=> $stable(active)); // R6

    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> !pwm_o); // R8

endmodule

// File: tb/backlight_pwm_tb_top.sv
module backlight_pwm_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    backlight_pwm dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pwm_o       (pwm)
    );

    // {div, per, high}
    localparam int NVEC = 10;
    localparam int VEC [NVEC][3] = '{
        '{0, 3, 1}, '{2, 4, 3}, '{1, 5, 9}, '{3, 7, 8}, '{0, 0, 0},
        '{4, 2, 0}, '{0, 0, 1}, '{9, 3, 2}, '{0, 4095, 4096}, '{1023, 0, 1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(rdata == exp, tag, int'(rdata), int'(exp));
    endtask

    task automatic wait_rise();
        logic prev;
        prev = pwm;
        forever begin
            @(negedge clk);
            if (pwm && !prev) break;
            prev = pwm;
        end
    endtask

    task automatic measure(output int hi, output int per);
        int lo;
        wait_rise();
        hi = 0; lo = 0;
        while (pwm) begin hi++; @(negedge clk); end
        while (!pwm) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    task automatic program_cfg(input int d, input int p, input int h);
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h4, 32'(d) << 16);
        wr_reg(4'h8, (32'(h) << 16) | 32'(p));
        wr_reg(4'hC, 32'h1);
        wr_reg(4'hC, 32'h0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int d, p, h, n, ehi, cnt, hi, per, c;
        logic last;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(pwm == 1'b0, "R1 pwm after reset", int'(pwm), 0);
        rd_check(4'h0, 32'h0, "R1 run reg");
        rd_check(4'h4, 32'h0, "R1 cfg reg");
        rd_check(4'h8, 32'h0, "R1 timing reg");
        rd_check(4'hC, 32'h0, "R1 commit reg");

        // R9: field layout on readback
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd_check(4'h4, 32'h03FF_0001, "R9 cfg fields");
        wr_reg(4'h8, 32'hFFFF_FFFF);
        rd_check(4'h8, 32'h1FFF_0FFF, "R9 timing fields");
        wr_reg(4'hC, 32'hFFFF_FFFF);
        rd_check(4'hC, 32'h1, "R9 commit field");
        wr_reg(4'hC, 32'h0);
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_check(4'h0, 32'h1, "R9 run field");
        wr_reg(4'h0, 32'h0);

        // Vector table: R2 frame length, R3 high time, R4 full-high
        for (int v = 0; v < NVEC; v++) begin
            d = VEC[v][0]; p = VEC[v][1]; h = VEC[v][2];
            n = (d + 1) * (p + 1);
            ehi = ((h > p + 1) ? (p + 1) : h) * (d + 1);
            program_cfg(d, p, h);
            wr_reg(4'h0, 32'h1);
            cnt = 0; last = 1'b0;
            for (int i = 0; i < n; i++) begin
                if (pwm) cnt++;
                last = pwm;
                @(negedge clk);
            end
            if (h > p) check(cnt == ehi, "R4 high cycles per frame", cnt, ehi);
            else       check(cnt == ehi, "R3 high cycles per frame", cnt, ehi);
            if (h > 0 && h <= p) begin
                check(last == 1'b0 && pwm == 1'b1, "R2 frame boundary", int'({last, pwm}), 1);
            end
        end

        // R5: uncommitted writes have no effect; read returns shadow
        program_cfg(0, 9, 5);
        wr_reg(4'h0, 32'h1);
        wr_reg(4'h8, (32'd1 << 16) | 32'd3);
        rd_check(4'h8, 32'h0001_0003, "R5 readback of shadow");
        measure(hi, per);
        check(hi == 5, "R5 high kept without commit", hi, 5);
        check(per == 10, "R5 period kept without commit", per, 10);

        // R6: commit mid-frame completes the current frame
        wait_rise();
        wr_reg(4'hC, 32'h1);
        check(pwm == 1'b1, "R6 frame not cut short", int'(pwm), 1);
        measure(hi, per);
        check(hi == 1 && per == 4, "R6 new values after boundary", hi * 100 + per, 104);
        wr_reg(4'hC, 32'h0);

        // R6: writing 1 over 1 does not arm
        wr_reg(4'hC, 32'h1);
        repeat (10) @(negedge clk);
        wr_reg(4'h8, (32'd2 << 16) | 32'd5);
        wr_reg(4'hC, 32'h1);
        repeat (10) @(negedge clk);
        measure(hi, per);
        check(hi == 1 && per == 4, "R6 no re-arm on level", hi * 100 + per, 104);
        wr_reg(4'hC, 32'h0);
        wr_reg(4'hC, 32'h1);
        measure(hi, per);
        check(hi == 2 && per == 6, "R6 re-arm on rising", hi * 100 + per, 206);
        wr_reg(4'hC, 32'h0);

        // R7: direct mode
        wr_reg(4'h4, 32'h1);
        wr_reg(4'h8, (32'd3 << 16) | 32'd7);
        measure(hi, per);
        check(hi == 3 && per == 8, "R7 direct update", hi * 100 + per, 308);
        wr_reg(4'h8, (32'd1 << 16) | 32'd2);
        measure(hi, per);
        check(hi == 1 && per == 3, "R7 direct second update", hi * 100 + per, 103);

        // R8: stop and restart
        wr_reg(4'h0, 32'h0);
        check(pwm == 1'b0, "R8 low after stop", int'(pwm), 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm) cnt++;
            @(negedge clk);
        end
        check(cnt == 0, "R8 held low while stopped", cnt, 0);
        wr_reg(4'h4, (32'd1 << 16) | 32'h1);
        wr_reg(4'h8, (32'd2 << 16) | 32'd5);
        wr_reg(4'h0, 32'h1);
        c = 0;
        while (pwm && c < 100) begin c++; @(negedge clk); end
        check(c == 4, "R8 fresh frame starts high", c, 4);
        measure(hi, per);
        check(hi == 4 && per == 12, "R2 frame with prescaler", hi * 100 + per, 412);

        summary();
        $finish;
    end

endmodule